// File: doc/BRIEF.md
# Mode-Selectable Magnitude Comparator

This block compares two operands of equal width and reports, on three separate flags, whether the first is equal to, greater than or less than the second. A single mode input chooses how the operand bits are read: as plain unsigned magnitudes, or as two's-complement signed values. The same bit pattern can therefore order differently depending on the mode.

Both operands are widened by one bit before they are compared. In signed mode the widening copies each operand's top bit. In unsigned mode it places a zero above the top bit. One subtractor then forms the difference for both modes, and the three flags are decoded from that difference. The block is purely combinational and has no clock or reset. The operand width is a parameter and defaults to 4 bits.

Top module: `mode_compare`

## Requirements
- R1: With `signedMode` = 0, both operands are read as unsigned integers in the range 0..15. `isGreater` is high exactly when opA > opB, and `isLess` is high exactly when opA < opB.
- R2: With `signedMode` = 1, both operands are read as two's-complement integers in the range -8..7, with bit 3 as the sign. `isGreater` is high exactly when opA > opB, and `isLess` is high exactly when opA < opB.
- R3: For every combination of inputs, exactly one of `isEqual`, `isGreater` and `isLess` is high.
- R4: `isEqual` is high exactly when opA and opB carry the same bit pattern, in either mode.
- R5: `isLess` is low whenever the operands are equal. It is not simply the inverse of `isGreater`.
- R6: The same operand bits can give opposite orderings in the two modes. For opA=4'b1000 and opB=4'b0001, the result is `isGreater` in mode 0 and `isLess` in mode 1.
- R7: The range extremes compare correctly. For opA=4'b1000 and opB=4'b0111, mode 0 gives greater and mode 1 gives less. For opA=4'b1111 and opB=4'b0000, mode 0 gives greater and mode 1 gives less. For opA=4'b0111 and opB=4'b1000 in mode 1, the result is greater.
- R8: The outputs follow any change on the inputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| signedMode | input | 1 | 0 = unsigned, 1 = two's-complement signed |
| isEqual | output | 1 | opA equals opB |
| isGreater | output | 1 | opA is greater than opB |
| isLess | output | 1 | opA is less than opB |

## Verification
The checker's assertions are evaluated whenever the ports change. They assume the inputs are driven to known 0/1 values, and they skip any evaluation in which an input or output is unknown. The bench assigns all three inputs together, with blocking writes, away from the clock edge, so no assertion ever sees a partly updated operand set. The stimulus covers the whole input space: a table of directed corner cases is followed by a sweep of all 256 operand pairs in both modes, checked against integer arithmetic.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  // Strobes from the mode control to the datapath.
  typedef struct packed {
    logic extendSign;  // replicate the operand's top bit when widening
  } ctrlStrobes_t;

endpackage

// File: rtl/cmp_ctrl.sv
module cmp_ctrl
  import cmp_pkg::*;
(
  input  logic         signedMode,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    strobes.extendSign = signedMode;
  end

endmodule

// File: rtl/cmp_datapath.sv
module cmp_datapath
  import cmp_pkg::*;
#(
  parameter int WIDTH = 4,
  localparam int DW = WIDTH + 1
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  ctrlStrobes_t     strobes,
  output logic [DW-1:0]    diff
);

  logic [DW-1:0] wideA;
  logic [DW-1:0] wideB;
  logic          topA;
  logic          topB;

  // Widening bit: the copied sign bit or a zero, picked by the strobe.
  always_comb begin
    topA = strobes.extendSign & opA[WIDTH-1];
    topB = strobes.extendSign & opB[WIDTH-1];
  end

  assign wideA = {topA, opA};
  assign wideB = {topB, opB};

  // One subtractor serves both modes.
  assign diff = wideA - wideB;

endmodule

// File: rtl/cmp_flags.sv
module cmp_flags #(
  parameter int WIDTH = 4,
  localparam int DW = WIDTH + 1
) (
  input  logic [DW-1:0] diff,
  output logic          isEqual,
  output logic          isGreater,
  output logic          isLess
);

  always_comb begin
    isEqual   = (diff == '0);
    isLess    = diff[DW-1];
    isGreater = ~isEqual & ~isLess;
  end

endmodule

// File: rtl/mode_compare.sv
module mode_compare
  import cmp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             signedMode,
  output logic             isEqual,
  output logic             isGreater,
  output logic             isLess
);

  localparam int DW = WIDTH + 1;

  ctrlStrobes_t  strobes;
  logic [DW-1:0] diff;

  cmp_ctrl u_ctrl (
    .signedMode (signedMode),
    .strobes    (strobes)
  );

  cmp_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .diff    (diff)
  );

  cmp_flags #(.WIDTH(WIDTH)) u_flags (
    .diff      (diff),
    .isEqual   (isEqual),
    .isGreater (isGreater),
    .isLess    (isLess)
  );

endmodule

// File: rtl/mode_compare_chk.sv
module mode_compare_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             signedMode,
  input logic             isEqual,
  input logic             isGreater,
  input logic             isLess
);

  logic known;
  assign known = !$isunknown({opA, opB, signedMode, isEqual, isGreater, isLess});

  always_comb begin
    if (known) begin
      AST_ONE_FLAG: assert ($onehot({isEqual, isGreater, isLess}));  // R3
      AST_EQ_PATTERN: assert (isEqual == (opA == opB));  // R4
      AST_LT_NOT_EQ: assert (!(isEqual && isLess));  // R5
      if (!signedMode) begin
        AST_UNSIGNED_ORDER: assert (isGreater == (opA > opB) && isLess == (opA < opB));  // R1
      end else begin
        AST_SIGNED_ORDER: assert (isGreater == ($signed(opA) > $signed(opB)) && isLess == ($signed(opA) < $signed(opB)));  // R2
      end
    end
  end

endmodule

bind mode_compare mode_compare_chk #(.WIDTH(WIDTH)) u_chk (
  .opA        (opA),
  .opB        (opB),
  .signedMode (signedMode),
  .isEqual    (isEqual),
  .isGreater  (isGreater),
  .isLess     (isLess)
);

// File: tb/mode_compare_test.sv
`timescale 1ns/1ps
module mode_compare_test;

  localparam int W = 4;
  localparam int NVEC = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [W-1:0] opA, opB;
  logic         signedMode;
  logic         isEqual, isGreater, isLess;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  mode_compare #(.WIDTH(W)) uut (
    .opA(opA), .opB(opB), .signedMode(signedMode),
    .isEqual(isEqual), .isGreater(isGreater), .isLess(isLess)
  );

  // Vector layout: {mode, A[3:0], B[3:0], expected {eq,gt,lt}}
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 4'b1000, 4'b0001, 3'b010},  // R6 unsigned
    {1'b1, 4'b1000, 4'b0001, 3'b001},  // R6 signed
    {1'b0, 4'b1000, 4'b0111, 3'b010},  // R7
    {1'b1, 4'b1000, 4'b0111, 3'b001},  // R7
    {1'b0, 4'b1111, 4'b0000, 3'b010},  // R7
    {1'b1, 4'b1111, 4'b0000, 3'b001},  // R7
    {1'b1, 4'b0111, 4'b1000, 3'b010},  // R7
    {1'b0, 4'b0000, 4'b0000, 3'b100},  // R5
    {1'b1, 4'b1000, 4'b1000, 3'b100},  // R5
    {1'b1, 4'b1111, 4'b1111, 3'b100}   // R5
  };

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s mode=%0b A=%b B=%b got eq/gt/lt=%b expected=%b",
               req, signedMode, opA, opB, got, exp);
    end
  endtask

  function automatic logic [2:0] refFlags(input logic m, input logic [3:0] a, input logic [3:0] b);
    int ia, ib;
    ia = int'(a);
    ib = int'(b);
    if (m) begin
      if (a[3]) ia = ia - 16;
      if (b[3]) ib = ib - 16;
    end
    if (ia == ib) return 3'b100;
    if (ia > ib)  return 3'b010;
    return 3'b001;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    opA = '0; opB = '0; signedMode = 1'b0;
    @(negedge clk); #1;
    check("R4 initial equal", {isEqual, isGreater, isLess}, 3'b100);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      signedMode = VEC[i][11];
      opA = VEC[i][10:7];
      opB = VEC[i][6:3];
      #1;
      check("R6/R7/R5 directed", {isEqual, isGreater, isLess}, VEC[i][2:0]);
    end

    // R8: outputs change with no clock edge in between
    @(posedge clk); #0.5;
    signedMode = 1'b0; opA = 4'b1000; opB = 4'b0001;
    #0.5;
    check("R8 comb", {isEqual, isGreater, isLess}, 3'b010);
    signedMode = 1'b1;
    #0.5;
    check("R8 comb mode flip", {isEqual, isGreater, isLess}, 3'b001);

    // Full sweep: R1 (mode 0), R2 (mode 1), plus R3/R4
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          logic [2:0] exp;
          @(negedge clk);
          signedMode = m[0];
          opA = a[3:0];
          opB = b[3:0];
          #1;
          exp = refFlags(m[0], a[3:0], b[3:0]);
          check(m == 0 ? "R1 sweep" : "R2 sweep", {isEqual, isGreater, isLess}, exp);
          checks++;
          if ($countones({isEqual, isGreater, isLess}) != 1) begin
            failures++;
            $display("FAIL R3 flags=%b expected one hot", {isEqual, isGreater, isLess});
          end
        end
      end
    end

    finishRun();
  end

endmodule